// File: doc/BRIEF.md
# Accelerating Pushbutton Position Counter

This block turns two active-low pushbutton lines into an 8-bit position value that feeds a DAC tap decoder. Each button line is synchronised and then qualified by a hold-time filter, so only a press that stays down long enough counts. The first qualified press moves the position by one step. If the button stays down, the block repeats the step: slowly for the first second of the hold, then quickly until the button is released. The position stops at both ends of its range and never wraps.

All timing comes from a one-millisecond tick enable that is derived elsewhere from the system clock. Every period is therefore a parameter given in ticks: the filter time, the slow interval, the fast interval and the time to acceleration. A lock input discards button activity. A load port writes a recalled value into the position. The load port is a plain valid strobe with no back-pressure: the block takes a load in any cycle in which `load_valid` is high, so no ready signal is needed.

Top module: `hold_step_counter`

## Requirements
- R1: After reset the position is 00h.
- R2: A button line (low means pressed) counts as pressed only after it has been seen low on DEB_TICKS consecutive ticks. A shorter low pulse changes nothing, and the next press must build up the full count again.
- R3: A qualified press on the increment button adds one to the position, and a qualified press on the decrement button subtracts one. The step happens in the cycle after the qualifying tick.
- R4: While one button stays qualified, a further step follows every SLOW_TICKS ticks until ACCEL_TICKS ticks of hold have passed. After that a step follows every FAST_TICKS ticks, counted from the last slow step. After n hold ticks the total is 1 + min(n,ACCEL)/SLOW + max(0,n-ACCEL)/FAST steps when ACCEL is a multiple of SLOW.
- R5: When the button is released the block returns to idle. The next press again gives a single step followed by the slow rate.
- R6: The position saturates: an increment at FFh and a decrement at 00h leave it unchanged.
- R7: While both buttons are qualified at once, no step occurs. When one is released, the other one starts again from a single step followed by the slow rate.
- R8: In a cycle with `load_valid` high, the position becomes `load_value` on the next edge. This overrides any button step in the same cycle.
- R9: While `lock` is high, the position does not change from buttons and the hold filters and repeat timers are cleared. A button still held when lock falls must qualify again from zero.
- R10: In any cycle without a load, the position moves by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle millisecond tick enable |
| inc_btn_n | input | 1 | Raw increment button, low when pressed |
| dec_btn_n | input | 1 | Raw decrement button, low when pressed |
| lock | input | 1 | Discard button activity and clear timers |
| load_valid | input | 1 | Load strobe for a recalled position |
| load_value | input | POS_W | Recalled position value |
| position | output | POS_W | Current tap position |

## Verification
The bench uses small tick counts and sweeps the hold length over every value from zero to past the acceleration point, in both directions, starting from mid-range. This separates first-step, slow-rate and fast-rate timing, including the switch between rates. Low pulses one tick short of the filter time, followed by a full press, show whether the filter restarts its count. Loads next to the range ends, overlapping presses of both buttons, lock during a hold, and a load on the same tick as a fast step each test one arbitration rule against saturation or priority.

// File: rtl/hold_step_counter_pkg.sv
package hold_step_counter_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SLOW = 2'd1,
    PH_FAST = 2'd2
  } scan_phase_e;

  typedef struct packed {
    logic fire;
    logic up;
  } step_cmd_t;

endpackage

// File: rtl/hsc_btn_filter.sv
module hsc_btn_filter #(
  parameter int DEB_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic lock,
  input  logic btn_n,
  output logic qualified
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic       sync_a, sync_b;
  logic [CW-1:0] hold_cnt;
  logic       pressed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= btn_n;
      sync_b <= sync_a;
    end
  end

  assign pressed = ~sync_b;

  always_ff @(posedge clk) begin
    if (!rst_n || lock || !pressed) begin
      hold_cnt <= '0;
    end else if (tick_1ms && hold_cnt != CW'(DEB_TICKS)) begin
      hold_cnt <= hold_cnt + CW'(1);
    end
  end

  assign qualified = (hold_cnt == CW'(DEB_TICKS));

endmodule

// File: rtl/hsc_repeat_engine.sv
module hsc_repeat_engine
  import hold_step_counter_pkg::*;
#(
  parameter int SLOW_TICKS  = 250,
  parameter int FAST_TICKS  = 50,
  parameter int ACCEL_TICKS = 1000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_1ms,
  input  logic      lock,
  input  logic      up_q,
  input  logic      dn_q,
  output step_cmd_t cmd
);
  localparam int RMAX = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int RW   = $clog2(RMAX + 1);
  localparam int HW   = $clog2(ACCEL_TICKS + 1);

  scan_phase_e   phase_q, phase_d;
  logic [RW-1:0] rep_q, rep_d, rep_inc, interval;
  logic [HW-1:0] hold_q, hold_d;
  logic          active, first, repeat_fire;

  assign active   = (up_q ^ dn_q) & ~lock;
  assign first    = active & (phase_q == PH_IDLE);
  assign interval = (phase_q == PH_FAST) ? RW'(FAST_TICKS) : RW'(SLOW_TICKS);
  assign rep_inc  = rep_q + RW'(1);

  always_comb begin
    phase_d     = phase_q;
    rep_d       = rep_q;
    hold_d      = hold_q;
    repeat_fire = 1'b0;
    if (!active) begin
      phase_d = PH_IDLE;
      rep_d   = '0;
      hold_d  = '0;
    end else if (first) begin
      phase_d = PH_SLOW;
      rep_d   = '0;
      hold_d  = '0;
    end else if (tick_1ms) begin
      if (rep_inc >= interval) begin
        rep_d       = '0;
        repeat_fire = 1'b1;
      end else begin
        rep_d = rep_inc;
      end
      if (phase_q == PH_SLOW) begin
        if (hold_q + HW'(1) == HW'(ACCEL_TICKS)) begin
          phase_d = PH_FAST;
        end
        hold_d = hold_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rep_q   <= '0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      rep_q   <= rep_d;
      hold_q  <= hold_d;
    end
  end

  assign cmd.fire = first | repeat_fire;
  assign cmd.up   = up_q;

endmodule

// File: rtl/hsc_position_reg.sv
module hsc_position_reg
  import hold_step_counter_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_cmd_t        cmd,
  input  logic             load_valid,
  input  logic [POS_W-1:0] load_value,
  output logic [POS_W-1:0] position
);
  localparam logic [POS_W-1:0] TOP = '1;
  localparam logic [POS_W-1:0] BOT = '0;

  logic [POS_W-1:0] pos_q, stepped;

  always_comb begin
    stepped = pos_q;
    if (cmd.fire) begin
      if (cmd.up && pos_q != TOP) begin
        stepped = pos_q + POS_W'(1);
      end else if (!cmd.up && pos_q != BOT) begin
        stepped = pos_q - POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= BOT;
    end else if (load_valid) begin
      pos_q <= load_value;
    end else begin
      pos_q <= stepped;
    end
  end

  assign position = pos_q;

endmodule

// File: rtl/hold_step_counter.sv
module hold_step_counter
  import hold_step_counter_pkg::*;
#(
  parameter int POS_W       = 8,
  parameter int DEB_TICKS   = 30,
  parameter int SLOW_TICKS  = 250,
  parameter int FAST_TICKS  = 50,
  parameter int ACCEL_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             inc_btn_n,
  input  logic             dec_btn_n,
  input  logic             lock,
  input  logic             load_valid,
  input  logic [POS_W-1:0] load_value,
  output logic [POS_W-1:0] position
);
  localparam int NBTN = 2;

  logic [NBTN-1:0] raw_n, qual;
  step_cmd_t       cmd;

  assign raw_n = {dec_btn_n, inc_btn_n};

  for (genvar b = 0; b < NBTN; b++) begin : g_btn
    hsc_btn_filter #(.DEB_TICKS(DEB_TICKS)) filt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_1ms  (tick_1ms),
      .lock      (lock),
      .btn_n     (raw_n[b]),
      .qualified (qual[b])
    );
  end

  hsc_repeat_engine #(
    .SLOW_TICKS  (SLOW_TICKS),
    .FAST_TICKS  (FAST_TICKS),
    .ACCEL_TICKS (ACCEL_TICKS)
  ) eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1ms (tick_1ms),
    .lock     (lock),
    .up_q     (qual[0]),
    .dn_q     (qual[1]),
    .cmd      (cmd)
  );

  hsc_position_reg #(.POS_W(POS_W)) pos_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .load_valid (load_valid),
    .load_value (load_value),
    .position   (position)
  );

endmodule

// File: rtl/hold_step_counter_chk.sv
module hold_step_counter_chk #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock,
  input logic             load_valid,
  input logic [POS_W-1:0] load_value,
  input logic [POS_W-1:0] position
);
  localparam logic [POS_W-1:0] TOP = '1;
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  // R8: a load always wins
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> position == $past(load_value));

  // R10: at most one step per cycle
  a_r10_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |=> (position == $past(position) ||
                     position == $past(position) + ONE ||
                     position == $past(position) - ONE));

  // R6: no wrap at the top
  a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && position == TOP) |=> position == TOP || position == TOP - ONE);

  // R6: no wrap at the bottom
  a_r6_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && position == '0) |=> position == '0 || position == ONE);

  // R9: lock freezes the position
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !load_valid) |=> $stable(position));

endmodule

bind hold_step_counter hold_step_counter_chk #(.POS_W(POS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock       (lock),
  .load_valid (load_valid),
  .load_value (load_value),
  .position   (position)
);

// File: tb/hold_step_counter_tb_top.sv
module hold_step_counter_tb_top;
  localparam int DEB = 3;
  localparam int SLW = 5;
  localparam int FST = 2;
  localparam int ACC = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic       inc_btn_n = 1'b1;
  logic       dec_btn_n = 1'b1;
  logic       lock = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_value = '0;
  logic [7:0] position;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  hold_step_counter #(
    .POS_W(8), .DEB_TICKS(DEB), .SLOW_TICKS(SLW),
    .FAST_TICKS(FST), .ACCEL_TICKS(ACC)
  ) dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not end, actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
      idle(6);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk) begin load_valid = 1'b1; load_value = 8'(v); end
    @(negedge clk) load_valid = 1'b0;
    idle(2);
  endtask

  task automatic press(input bit up);
    @(negedge clk);
    if (up) inc_btn_n = 1'b0; else dec_btn_n = 1'b0;
    idle(3);
  endtask

  task automatic release_all();
    @(negedge clk) begin inc_btn_n = 1'b1; dec_btn_n = 1'b1; end
    idle(5);
  endtask

  function automatic int steps(input int n);
    int s;
    s = 1 + ((n < ACC) ? n : ACC) / SLW;
    if (n > ACC) s += (n - ACC) / FST;
    return s;
  endfunction

  function automatic int sat(input int v);
    return (v > 255) ? 255 : ((v < 0) ? 0 : v);
  endfunction

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    chk("R1 reset position", int'(position), 0);

    // R2: short pulse ignored, then a full press steps once (R3)
    press(1'b1); run_ticks(DEB - 1); release_all();
    chk("R2 short pulse ignored", int'(position), 0);
    press(1'b1); run_ticks(DEB);
    chk("R3 single increment", int'(position), 1);
    release_all();
    press(1'b0); run_ticks(DEB - 1); release_all();
    chk("R2 short decrement pulse ignored", int'(position), 1);

    // R4/R5 sweep of hold length, both directions
    for (int n = 0; n <= 16; n++) begin
      do_load(100);
      press(1'b1); run_ticks(DEB + n);
      chk($sformatf("R4 up hold %0d", n), int'(position), sat(100 + steps(n)));
      release_all();
      do_load(100);
      press(1'b0); run_ticks(DEB + n);
      chk($sformatf("R4 down hold %0d", n), int'(position), sat(100 - steps(n)));
      release_all();
    end

    // R5: restart after release
    do_load(20);
    press(1'b1); run_ticks(DEB + 12); release_all();
    press(1'b1); run_ticks(DEB + 2);
    chk("R5 restart single step", int'(position), 20 + steps(12) + 1);
    run_ticks(3);
    chk("R5 restart slow rate", int'(position), 20 + steps(12) + 2);
    release_all();

    // R6: saturation
    do_load(253);
    press(1'b1); run_ticks(DEB + 16);
    chk("R6 saturate at FFh", int'(position), 255);
    release_all();
    do_load(2);
    press(1'b0); run_ticks(DEB + 16);
    chk("R6 saturate at 00h", int'(position), 0);
    release_all();

    // R7: both buttons
    do_load(60);
    press(1'b1); run_ticks(DEB);
    chk("R7 first button steps", int'(position), 61);
    press(1'b0); run_ticks(DEB + 20);
    chk("R7 both held no step", int'(position), 61);
    @(negedge clk) inc_btn_n = 1'b1;
    idle(6);
    chk("R7 remaining button single step", int'(position), 60);
    run_ticks(SLW);
    chk("R7 remaining button slow rate", int'(position), 59);
    release_all();

    // R9: lock
    do_load(50);
    @(negedge clk) lock = 1'b1;
    press(1'b1); run_ticks(DEB + 8);
    chk("R9 locked press ignored", int'(position), 50);
    @(negedge clk) lock = 1'b0;
    run_ticks(DEB - 1);
    chk("R9 requalify after unlock", int'(position), 50);
    run_ticks(1);
    chk("R9 step after requalify", int'(position), 51);
    release_all();

    // R8: load on the same tick as a fast step
    do_load(128);
    press(1'b1); run_ticks(DEB + 11);
    chk("R8 before collision", int'(position), 128 + steps(11));
    @(negedge clk) begin tick_1ms = 1'b1; load_valid = 1'b1; load_value = 8'h40; end
    @(negedge clk) begin tick_1ms = 1'b0; load_valid = 1'b0; end
    idle(6);
    chk("R8 load beats step", int'(position), 64);
    run_ticks(FST);
    chk("R8 fast scan continues", int'(position), 65);
    release_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule